// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the word-select (frame) clock for an audio serial port. In master mode it divides its own clock, which is the audio master clock, by a programmable prescale of 2 or 4 to form the bit clock. It counts 32, 64 or 128 bit periods per frame and drives word-select low for the first half of each frame and high for the second. In slave mode it takes a bit clock and a word-select from an external device, passes them through a synchroniser and forwards them. In both modes it also emits one-cycle strobes that mark bit and frame boundaries for the serializer.

The outputs carry programmable polarity. In master mode the bit clock can run freely, or it can be gated so that it only pulses during the active slot bits of each half-frame. Clocks run only while the global enable is set and at least one of the transmit or receive channels is enabled. A new prescale or frame ratio is held back until the current frame ends, so no shortened pulse or frame is ever produced. The block carries no data stream, so every pin is a plain control or status level; no valid/ready handshake applies.

Top module: `audio_clkgen`

## Requirements
- R1: Run is `glb_en & (tx_en | rx_en)`. While run is low, `bclk_o` equals `cfg_bclk_inv`, `ws_o` equals `cfg_ws_inv`, and both strobes are 0, from the first clock edge after run falls. After reset all outputs are 0.
- R2: In master mode a bit period lasts 2 clock cycles when `cfg_mclk_div`=0 and 4 when it is 1. Before polarity, the bit clock is low in the first half of the period and high in the second half.
- R3: In master mode a frame lasts 32, 64 or 128 bit periods for `cfg_frame_sel` = 0, 1 or 2; code 3 also selects 128.
- R4: In master mode, with polarity removed, word-select is 0 for exactly the first half of the frame and 1 for exactly the second half. It changes only right after a bit strobe.
- R5: In master mode `bit_stb` is high for one cycle in the last cycle of every bit period. `frame_stb` is high only together with the `bit_stb` that ends a frame, once per frame.
- R6: A change of `cfg_mclk_div` or `cfg_frame_sel` while running does not alter the current frame; it applies from the next frame.
- R7: `cfg_bclk_inv`=1 inverts `bclk_o` and `cfg_ws_inv`=1 inverts `ws_o`, in both modes.
- R8: In master mode with `cfg_free_run`=0, bit-clock pulses appear only for bit positions within each half-frame that lie below the slot width. Slot width is 16, 24 or 32 bits for `cfg_slot_sel` = 0, 1 or 2, and 3 means 32. Strobes are unaffected. With `cfg_free_run`=1 every bit period pulses.
- R9: Either `tx_en` or `rx_en` alone, together with `glb_en`, is enough to run the clocks.
- R10: In slave mode (`cfg_master`=0), `ext_bclk` and `ext_ws` pass through a two-stage synchroniser and an output register. `bclk_o` = synced `ext_bclk` ^ `cfg_bclk_inv` and `ws_o` = synced `ext_ws` ^ `cfg_ws_inv`, so a pin change shows on the outputs after the third rising clock edge.
- R11: In slave mode `bit_stb` pulses for one cycle on each rising edge of `ext_bclk`, and `frame_stb` pulses for one cycle on each falling edge of `ext_ws`. Both have the same latency as R10. No strobe follows the opposite edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock; all logic is on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global clock enable |
| tx_en | input | 1 | Transmit channel enabled |
| rx_en | input | 1 | Receive channel enabled |
| cfg_master | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| cfg_mclk_div | input | 1 | Prescale select: 0 = 2, 1 = 4 |
| cfg_frame_sel | input | 2 | Bits per frame: 0 = 32, 1 = 64, 2/3 = 128 |
| cfg_slot_sel | input | 2 | Active slot width: 0 = 16, 1 = 24, 2/3 = 32 |
| cfg_free_run | input | 1 | 1 = bit clock never gated |
| cfg_bclk_inv | input | 1 | Bit-clock polarity invert |
| cfg_ws_inv | input | 1 | Word-select polarity invert |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_ws | input | 1 | External word-select (slave mode) |
| bclk_o | output | 1 | Bit clock out |
| ws_o | output | 1 | Word-select out |
| bit_stb | output | 1 | One-cycle bit boundary strobe |
| frame_stb | output | 1 | One-cycle frame boundary strobe |

## Verification
The properties assume that the polarity and mode inputs stay steady for a few cycles around the points they judge. The master-mode properties are therefore guarded by the past values of `cfg_master`, run and `cfg_ws_inv`. The single-cycle bit strobe property also assumes an external bit clock slower than half the master clock, with each level held for at least one cycle. The stimulus meets both conditions: it changes configuration only while the clocks are stopped, except in the ratio-change scenario, which touches only the ratios. It also drives the external clocks with levels held for many cycles.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int MAX_FRAME_BITS = 128;
  localparam int BCNT_W         = $clog2(MAX_FRAME_BITS);
  localparam int MAX_PRESCALE   = 4;
  localparam int PCNT_W         = $clog2(MAX_PRESCALE);

  typedef enum logic [1:0] {
    FRM_32     = 2'd0,
    FRM_64     = 2'd1,
    FRM_128    = 2'd2,
    FRM_128_B  = 2'd3
  } frame_sel_e;

  typedef enum logic [1:0] {
    SLOT_16    = 2'd0,
    SLOT_24    = 2'd1,
    SLOT_32    = 2'd2,
    SLOT_32_B  = 2'd3
  } slot_sel_e;

  typedef struct packed {
    logic bclk;
    logic ws;
    logic bit_stb;
    logic frame_stb;
  } clk_bundle_t;

  function automatic logic [PCNT_W:0] prescale_of(input logic sel);
    return sel ? (PCNT_W+1)'(4) : (PCNT_W+1)'(2);
  endfunction

  function automatic logic [BCNT_W:0] frame_bits_of(input logic [1:0] sel);
    case (frame_sel_e'(sel))
      FRM_32:  return (BCNT_W+1)'(32);
      FRM_64:  return (BCNT_W+1)'(64);
      default: return (BCNT_W+1)'(128);
    endcase
  endfunction

  function automatic logic [BCNT_W:0] slot_bits_of(input logic [1:0] sel);
    case (slot_sel_e'(sel))
      SLOT_16: return (BCNT_W+1)'(16);
      SLOT_24: return (BCNT_W+1)'(24);
      default: return (BCNT_W+1)'(32);
    endcase
  endfunction

endpackage

// File: rtl/aclk_master_div.sv
module aclk_master_div
  import aclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        mclk_div_sel,
  input  logic [1:0]  frame_sel,
  input  logic [1:0]  slot_sel,
  input  logic        free_run,
  output clk_bundle_t gen
);

  localparam logic [PCNT_W:0] P_ONE = (PCNT_W+1)'(1);
  localparam logic [BCNT_W:0] B_ONE = (BCNT_W+1)'(1);

  logic              running;
  logic [PCNT_W-1:0] pcnt;
  logic [BCNT_W-1:0] bcnt;
  logic              act_div;
  logic [1:0]        act_frm;

  logic [PCNT_W:0]   div_n;
  logic [PCNT_W:0]   pcnt_x;
  logic [BCNT_W:0]   fbits;
  logic [BCNT_W:0]   half;
  logic [BCNT_W:0]   bcnt_x;
  logic [BCNT_W:0]   slot_pos;
  logic              last_phase;
  logic              hi_phase;
  logic              last_bit;
  logic              in_slot;

  assign div_n      = prescale_of(act_div);
  assign fbits      = frame_bits_of(act_frm);
  assign half       = fbits >> 1;
  assign pcnt_x     = {1'b0, pcnt};
  assign bcnt_x     = {1'b0, bcnt};
  assign last_phase = (pcnt_x == div_n - P_ONE);
  assign hi_phase   = (pcnt_x >= (div_n >> 1));
  assign last_bit   = (bcnt_x == fbits - B_ONE);
  assign slot_pos   = bcnt_x & (half - B_ONE);
  assign in_slot    = (slot_pos < slot_bits_of(slot_sel));

  always_comb begin
    gen           = '0;
    gen.bclk      = running & hi_phase & (free_run | in_slot);
    gen.ws        = running & (bcnt_x >= half);
    gen.bit_stb   = running & last_phase;
    gen.frame_stb = running & last_phase & last_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pcnt    <= '0;
      bcnt    <= '0;
      act_div <= 1'b0;
      act_frm <= '0;
    end else if (!run) begin
      running <= 1'b0;
      pcnt    <= '0;
      bcnt    <= '0;
      act_div <= mclk_div_sel;
      act_frm <= frame_sel;
    end else begin
      running <= 1'b1;
      if (running) begin
        if (last_phase) begin
          pcnt <= '0;
          if (last_bit) begin
            bcnt    <= '0;
            act_div <= mclk_div_sel;
            act_frm <= frame_sel;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/aclk_slave_sync.sv
module aclk_slave_sync
  import aclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_bclk,
  input  logic        ext_ws,
  output clk_bundle_t sl
);

  localparam int N_LINES = 2;
  localparam int L_BCLK  = 0;
  localparam int L_WS    = 1;

  logic [N_LINES-1:0] ext_in;
  logic [N_LINES-1:0] synced;
  logic [N_LINES-1:0] delayed;

  assign ext_in = {ext_ws, ext_bclk};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], ext_in[g]};
    end
    assign synced[g]  = sh[SYNC_STAGES-1];
    assign delayed[g] = sh[SYNC_STAGES];
  end

  always_comb begin
    sl           = '0;
    sl.bclk      = synced[L_BCLK];
    sl.ws        = synced[L_WS];
    sl.bit_stb   = synced[L_BCLK] & ~delayed[L_BCLK];
    sl.frame_stb = ~synced[L_WS] & delayed[L_WS];
  end

endmodule

// File: rtl/aclk_out_stage.sv
module aclk_out_stage
  import aclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        sel_master,
  input  clk_bundle_t gen,
  input  clk_bundle_t sl,
  input  logic        bclk_inv,
  input  logic        ws_inv,
  output logic        bclk_o,
  output logic        ws_o,
  output logic        bit_stb,
  output logic        frame_stb
);

  clk_bundle_t pick;

  always_comb begin
    if (!run)            pick = '0;
    else if (sel_master) pick = gen;
    else                 pick = sl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_o    <= 1'b0;
      ws_o      <= 1'b0;
      bit_stb   <= 1'b0;
      frame_stb <= 1'b0;
    end else begin
      bclk_o    <= pick.bclk ^ bclk_inv;
      ws_o      <= pick.ws ^ ws_inv;
      bit_stb   <= pick.bit_stb;
      frame_stb <= pick.frame_stb;
    end
  end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import aclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       glb_en,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       cfg_master,
  input  logic       cfg_mclk_div,
  input  logic [1:0] cfg_frame_sel,
  input  logic [1:0] cfg_slot_sel,
  input  logic       cfg_free_run,
  input  logic       cfg_bclk_inv,
  input  logic       cfg_ws_inv,
  input  logic       ext_bclk,
  input  logic       ext_ws,
  output logic       bclk_o,
  output logic       ws_o,
  output logic       bit_stb,
  output logic       frame_stb
);

  logic        run;
  clk_bundle_t gen_b;
  clk_bundle_t sl_b;

  assign run = glb_en & (tx_en | rx_en);

  aclk_master_div u_mdiv (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run & cfg_master),
    .mclk_div_sel (cfg_mclk_div),
    .frame_sel    (cfg_frame_sel),
    .slot_sel     (cfg_slot_sel),
    .free_run     (cfg_free_run),
    .gen          (gen_b)
  );

  aclk_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ssync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_bclk (ext_bclk),
    .ext_ws   (ext_ws),
    .sl       (sl_b)
  );

  aclk_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .sel_master (cfg_master),
    .gen        (gen_b),
    .sl         (sl_b),
    .bclk_inv   (cfg_bclk_inv),
    .ws_inv     (cfg_ws_inv),
    .bclk_o     (bclk_o),
    .ws_o       (ws_o),
    .bit_stb    (bit_stb),
    .frame_stb  (frame_stb)
  );

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic glb_en,
  input logic tx_en,
  input logic rx_en,
  input logic cfg_master,
  input logic cfg_bclk_inv,
  input logic cfg_ws_inv,
  input logic bclk_o,
  input logic ws_o,
  input logic bit_stb,
  input logic frame_stb
);

  logic [1:0] age;
  logic       settled;
  logic       run_c;

  always_ff @(posedge clk) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign settled = (age == 2'd3);
  assign run_c   = glb_en & (tx_en | rx_en);

  // R1: stopped clocks sit at their idle polarity with no strobes
  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    settled && $past(!run_c) |->
      bclk_o == $past(cfg_bclk_inv) && ws_o == $past(cfg_ws_inv) && !bit_stb && !frame_stb);

  // R5: a bit strobe never lasts longer than one cycle
  a_r5_bit_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    settled && bit_stb |=> !bit_stb);

  // R5: in master mode a frame strobe coincides with a bit strobe
  a_r5_frame_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    settled && frame_stb && $past(cfg_master) |-> bit_stb);

  // R4: word-select moves only right after a bit boundary
  a_r4_ws_moves_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    settled && ws_o != $past(ws_o)
      && $past(cfg_master) && $past(cfg_master, 2) && $past(cfg_master, 3)
      && $past(run_c) && $past(run_c, 2) && $past(run_c, 3)
      && $past(cfg_ws_inv) == $past(cfg_ws_inv, 2)
      |-> $past(bit_stb));

  // R11: a slave frame strobe marks the start of the left half
  a_r11_slave_frame_left: assert property (@(posedge clk) disable iff (!rst_n)
    settled && frame_stb && $past(!cfg_master) |-> ws_o == $past(cfg_ws_inv));

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .glb_en       (glb_en),
  .tx_en        (tx_en),
  .rx_en        (rx_en),
  .cfg_master   (cfg_master),
  .cfg_bclk_inv (cfg_bclk_inv),
  .cfg_ws_inv   (cfg_ws_inv),
  .bclk_o       (bclk_o),
  .ws_o         (ws_o),
  .bit_stb      (bit_stb),
  .frame_stb    (frame_stb)
);

// File: tb/tb_audio_clkgen.sv
module tb_audio_clkgen;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
  logic       cfg_master = 1'b1, cfg_mclk_div = 1'b0;
  logic [1:0] cfg_frame_sel = 2'd0, cfg_slot_sel = 2'd0;
  logic       cfg_free_run = 1'b1, cfg_bclk_inv = 1'b0, cfg_ws_inv = 1'b0;
  logic       ext_bclk = 1'b0, ext_ws = 1'b0;
  logic       bclk_o, ws_o, bit_stb, frame_stb;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  audio_clkgen dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .tx_en(tx_en), .rx_en(rx_en),
    .cfg_master(cfg_master), .cfg_mclk_div(cfg_mclk_div),
    .cfg_frame_sel(cfg_frame_sel), .cfg_slot_sel(cfg_slot_sel),
    .cfg_free_run(cfg_free_run), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_ws_inv(cfg_ws_inv), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
    .bclk_o(bclk_o), .ws_o(ws_o), .bit_stb(bit_stb), .frame_stb(frame_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Stop clocks, apply a master configuration, start again.
  task automatic start_master(input logic div, input logic [1:0] frm,
                              input logic [1:0] slot, input logic free,
                              input logic binv, input logic winv);
    @(negedge clk);
    glb_en = 1'b0;
    cfg_master = 1'b1; cfg_mclk_div = div; cfg_frame_sel = frm;
    cfg_slot_sel = slot; cfg_free_run = free;
    cfg_bclk_inv = binv; cfg_ws_inv = winv;
    tx_en = 1'b1; rx_en = 1'b0;
    repeat (2) @(negedge clk);
    glb_en = 1'b1;
  endtask

  task automatic wait_frame(output bit found);
    found = 1'b0;
    for (int i = 0; i < 3000 && !found; i++) begin
      @(negedge clk);
      if (frame_stb) found = 1'b1;
    end
  endtask

  // Observe one full frame right after a frame strobe.
  task automatic measure(input int mdiv, input int fbits, input int act_bits,
                         input string tag_clk);
    int  f_len = mdiv * fbits;
    int  act_c = 0, rise_c = 0, hi_c = 0, bs_c = 0, fs_c = 0, first_hi = 0;
    bit  found, prev_act, last_fs = 1'b0, cur;
    wait_frame(found);
    chk(found, "R3 frame strobe present", found, 1);
    prev_act = (bclk_o != cfg_bclk_inv);
    for (int k = 1; k <= f_len; k++) begin
      @(negedge clk);
      cur = (bclk_o != cfg_bclk_inv);
      if (cur) act_c++;
      if (cur && !prev_act) rise_c++;
      prev_act = cur;
      if (ws_o != cfg_ws_inv) begin
        hi_c++;
        if (first_hi == 0) first_hi = k;
      end
      bs_c += int'(bit_stb);
      fs_c += int'(frame_stb);
      if (k == f_len) last_fs = frame_stb;
    end
    chk(bs_c == fbits, "R5 bit strobes per frame", bs_c, fbits);
    chk(fs_c == 1 && last_fs, "R3 frame length", fs_c, 1);
    chk(hi_c == f_len / 2, "R4 ws second-half length", hi_c, f_len / 2);
    chk(first_hi == f_len / 2 + 1, "R4 ws toggle position", first_hi, f_len / 2 + 1);
    chk(rise_c == act_bits, {tag_clk, " bit clock pulses"}, rise_c, act_bits);
    chk(act_c == act_bits * mdiv / 2, {tag_clk, " bit clock active cycles"},
        act_c, act_bits * mdiv / 2);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(bclk_o == 1'b0 && ws_o == 1'b0, "R1 reset levels", {bclk_o, ws_o}, 0);
    chk(!bit_stb && !frame_stb, "R1 reset strobes", {bit_stb, frame_stb}, 0);
  endtask

  task automatic t_ratios();
    start_master(1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0); measure(2, 32, 32, "R2");
    start_master(1'b1, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0); measure(4, 32, 32, "R2");
    start_master(1'b0, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0); measure(2, 64, 64, "R3");
    start_master(1'b1, 2'd2, 2'd2, 1'b1, 1'b0, 1'b0); measure(4, 128, 128, "R3");
    start_master(1'b0, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0); measure(2, 128, 128, "R3");
  endtask

  task automatic t_polarity();
    start_master(1'b1, 2'd0, 2'd2, 1'b1, 1'b1, 1'b1); measure(4, 32, 32, "R7");
  endtask

  task automatic t_gating();
    // R8: 64-bit frame, 16-bit slot -> 2*16 pulses
    start_master(1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0); measure(2, 64, 32, "R8");
    // R8: 128-bit frame, 24-bit slot, inverted clock
    start_master(1'b1, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0); measure(4, 128, 48, "R8");
    // R8: 32-bit frame, slot wider than half-frame -> no gating
    start_master(1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0); measure(2, 32, 32, "R8");
  endtask

  task automatic t_ratio_change();
    bit found;
    int gap1 = 0, gap2 = 0;
    start_master(1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0);
    wait_frame(found);
    for (int k = 1; k <= 2000 && gap1 == 0; k++) begin
      @(negedge clk);
      if (frame_stb) gap1 = k;
      if (k == 10) begin cfg_frame_sel = 2'd1; cfg_mclk_div = 1'b1; end
    end
    chk(gap1 == 64, "R6 current frame keeps old ratio", gap1, 64);
    for (int k = 1; k <= 2000 && gap2 == 0; k++) begin
      @(negedge clk);
      if (frame_stb) gap2 = k;
    end
    chk(gap2 == 256, "R6 next frame uses new ratio", gap2, 256);
  endtask

  task automatic t_disable();
    int strobes = 0, bad_lvl = 0;
    start_master(1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    glb_en = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      strobes += int'(bit_stb) + int'(frame_stb);
      if (bclk_o != 1'b1 || ws_o != 1'b1) bad_lvl++;
    end
    chk(strobes == 0, "R1 no strobes when stopped", strobes, 0);
    chk(bad_lvl == 0, "R1 idle levels follow polarity", bad_lvl, 0);
  endtask

  task automatic t_either_enable();
    int cnt = 0;
    bit found;
    start_master(1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0);
    tx_en = 1'b0; rx_en = 1'b1;
    wait_frame(found);
    chk(found, "R9 receive enable alone runs clocks", found, 1);
    rx_en = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cnt += int'(bit_stb);
    end
    chk(cnt == 0, "R9 no channel enabled stops clocks", cnt, 0);
  endtask

  task automatic t_slave();
    @(negedge clk);
    glb_en = 1'b0;
    cfg_master = 1'b0; cfg_bclk_inv = 1'b1; cfg_ws_inv = 1'b1;
    ext_bclk = 1'b0; ext_ws = 1'b1;
    tx_en = 1'b1; glb_en = 1'b1;
    repeat (8) @(negedge clk);
    chk(bclk_o == 1'b1, "R10 bclk polarity pass-through", bclk_o, 1);
    chk(ws_o == 1'b0, "R10 ws polarity pass-through", ws_o, 0);
    ext_bclk = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(bclk_o == 1'b1 && !bit_stb, "R10 synchroniser depth", {bclk_o, bit_stb}, 2);
    @(posedge clk);
    @(negedge clk);
    chk(bclk_o == 1'b0, "R10 bclk after sync", bclk_o, 0);
    chk(bit_stb == 1'b1, "R11 bit strobe on rising bclk", bit_stb, 1);
    @(negedge clk);
    chk(bit_stb == 1'b0, "R11 bit strobe one cycle", bit_stb, 0);
    ext_bclk = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        seen += int'(bit_stb);
      end
      chk(seen == 0, "R11 no strobe on falling bclk", seen, 0);
    end
    ext_ws = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frame_stb == 1'b1, "R11 frame strobe on falling ws", frame_stb, 1);
    chk(ws_o == 1'b1, "R11 ws left level at frame start", ws_o, 1);
    @(negedge clk);
    chk(frame_stb == 1'b0, "R11 frame strobe one cycle", frame_stb, 0);
    ext_ws = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        seen += int'(frame_stb);
      end
      chk(seen == 0, "R11 no frame strobe on rising ws", seen, 0);
    end
    glb_en = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ratios();
    t_polarity();
    t_gating();
    t_ratio_change();
    t_disable();
    t_either_enable();
    t_slave();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule